// File: doc/BRIEF.md
# USB Peripheral Attach and Chirp Sequencer

This block is the link-side controller that takes a ULPI transceiver from power-up to the start of high-speed negotiation as a USB peripheral. It pulses the transceiver reset and waits for the transceiver to raise and then release its bus-direction pin. It waits for a first receive-command report, then asks a separate register-write engine for two writes. The first write turns off the on-the-go features. The second selects full-speed peripheral operation with the D+ pull-up on.

When the transceiver reports the full-speed idle line state (J), the block watches the line-state reports for a host reset. Once SE0 has lasted long enough, it switches the transceiver to high-speed chirp operation and requests a chirp K transmission, then signals completion. Every step that waits on the transceiver or the engine has a time limit and falls into a sticky error state. The full-speed idle step has no limit, because the host may attach at any time. The block runs on the 60 MHz ULPI clock.

Top module: `usb_attach_seq`

## Requirements
- R1: While `rst_n` is low, and for exactly `RST_CYCLES` clock cycles after it rises, `phy_rst` is high, `state` is 0 and `req_valid` is low.
- R2: After the reset pulse (`state` 1), the block waits for `phy_dir` high (`state` 2), then waits for `phy_dir` low (`state` 3). It issues no request before that point.
- R3: A receive command is a cycle where `phy_dir` is high in that cycle and in the one before, and `phy_nxt` is low. Its `phy_data[1:0]` becomes `line_state` (00 SE0, 01 J, 10 K). In `state` 3 the first receive command moves to `state` 4, and a `phy_dir` high with `phy_nxt` high is not one.
- R4: In `state` 4 the block raises `req_valid` with `req_cmd` 0x8A and `req_data` 0x00. These values are held unchanged until the cycle in which `req_ack` is high.
- R5: After that acknowledge, it requests `req_cmd` 0x84 with `req_data` 0x45 (`state` 5). The acknowledge moves it to `state` 6.
- R6: In `state` 6 only a receive command reporting line state 01 moves to full-speed idle (`state` 7). Other line states leave it in `state` 6.
- R7: In `state` 7 the block moves to `state` 8 at the end of the `SE0_CYCLES`-th consecutive cycle in which the line state is SE0. A receive command in that cycle counts with its own value. Any receive command reporting a non-SE0 state restarts the count.
- R8: In `state` 8 it requests `req_cmd` 0x84 with `req_data` 0x54. The acknowledge moves it to `state` 9.
- R9: In `state` 9 it requests `req_cmd` 0x40 with `req_data` 0x00. The acknowledge moves it to `state` 10, with `done` high for exactly that first cycle, and it stays in `state` 10.
- R10: In any of states 1 to 6, 8 and 9, after `TIMEOUT` cycles in the same state, it moves to `state` 15 with `err` high. It stays there until `rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz ULPI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_dir | input | 1 | Transceiver bus-direction pin |
| phy_nxt | input | 1 | Transceiver next pin |
| phy_data | input | 8 | Data bus as driven by the transceiver |
| req_ack | input | 1 | Register-write engine finished the current request |
| phy_rst | output | 1 | Reset to the transceiver, active high |
| req_valid | output | 1 | Request pending to the register-write engine |
| req_cmd | output | 8 | Command byte of the request |
| req_data | output | 8 | Data byte of the request |
| state | output | 4 | Current sequencer step (codes in R1 to R10) |
| line_state | output | 2 | Line state from the most recent receive command |
| done | output | 1 | One-cycle pulse when the chirp request completes |
| err | output | 1 | Sticky timeout flag |

## Verification
A receive command finishes three falling edges after the bench starts it: one turnaround cycle, then one data cycle. Its effect on `line_state` and `state` is checked at the falling edge after the clock edge that samples the data. Moves caused by acknowledges and by pin levels show one clock edge later and are checked at the next falling edge. The reset pulse, timeouts and SE0 qualification are counted in falling-edge samples. These are expected to equal `RST_CYCLES`, `TIMEOUT` and `SE0_CYCLES - 1` exactly. The SE0 sweep breaks the SE0 run at every length below the threshold, then checks the edge just before and the edge of the switch.

// File: rtl/usb_attach_seq.sv
module usb_attach_seq #(
  parameter int RST_CYCLES = 16,
  parameter int SE0_CYCLES = 150,
  parameter int TIMEOUT    = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phy_dir,
  input  logic       phy_nxt,
  input  logic [7:0] phy_data,
  input  logic       req_ack,
  output logic       phy_rst,
  output logic       req_valid,
  output logic [7:0] req_cmd,
  output logic [7:0] req_data,
  output logic [3:0] state,
  output logic [1:0] line_state,
  output logic       done,
  output logic       err
);
  localparam int CNT_MAX = (TIMEOUT > RST_CYCLES) ? TIMEOUT : RST_CYCLES;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int SW = $clog2(SE0_CYCLES + 1);

  typedef enum logic [3:0] {
    S_RESET = 4'd0, S_DIR_HI = 4'd1, S_DIR_LO = 4'd2, S_FIRST_RX = 4'd3,
    S_OTG_OFF = 4'd4, S_FS_SEL = 4'd5, S_WAIT_J = 4'd6, S_FS_IDLE = 4'd7,
    S_HS_SEL = 4'd8, S_CHIRP = 4'd9, S_DONE = 4'd10, S_ERR = 4'd15
  } st_t;

  st_t st, st_nx;
  logic [CW-1:0] cnt;
  logic [SW-1:0] se0_cnt;
  logic dir_q;
  logic [1:0] ls_q;

  wire       rx_hit  = phy_dir & dir_q & ~phy_nxt;
  wire [1:0] rx_ls   = phy_data[1:0];
  wire       se0_now = rx_hit ? (rx_ls == 2'b00) : (ls_q == 2'b00);
  wire       waiting = (st inside {S_DIR_HI, S_DIR_LO, S_FIRST_RX, S_OTG_OFF,
                                   S_FS_SEL, S_WAIT_J, S_HS_SEL, S_CHIRP});

  always_comb begin
    st_nx = st;
    case (st)
      S_RESET:    if (cnt == CW'(RST_CYCLES - 1)) st_nx = S_DIR_HI;
      S_DIR_HI:   if (phy_dir) st_nx = S_DIR_LO;
      S_DIR_LO:   if (!phy_dir) st_nx = S_FIRST_RX;
      S_FIRST_RX: if (rx_hit) st_nx = S_OTG_OFF;
      S_OTG_OFF:  if (req_ack) st_nx = S_FS_SEL;
      S_FS_SEL:   if (req_ack) st_nx = S_WAIT_J;
      S_WAIT_J:   if (rx_hit && rx_ls == 2'b01) st_nx = S_FS_IDLE;
      S_FS_IDLE:  if (se0_now && se0_cnt == SW'(SE0_CYCLES - 1)) st_nx = S_HS_SEL;
      S_HS_SEL:   if (req_ack) st_nx = S_CHIRP;
      S_CHIRP:    if (req_ack) st_nx = S_DONE;
      default:    st_nx = st;
    endcase
    if (waiting && st_nx == st && cnt == CW'(TIMEOUT - 1)) st_nx = S_ERR;
  end

  always_comb begin
    req_cmd  = 8'h00;
    req_data = 8'h00;
    case (st)
      S_OTG_OFF: req_cmd = 8'h8A;
      S_FS_SEL:  begin req_cmd = 8'h84; req_data = 8'h45; end
      S_HS_SEL:  begin req_cmd = 8'h84; req_data = 8'h54; end
      S_CHIRP:   req_cmd = 8'h40;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_RESET;
      cnt     <= '0;
      se0_cnt <= '0;
      dir_q   <= 1'b0;
      ls_q    <= 2'b00;
      done    <= 1'b0;
    end else begin
      st    <= st_nx;
      dir_q <= phy_dir;
      done  <= (st == S_CHIRP) && req_ack;
      if (rx_hit) ls_q <= rx_ls;
      if (st_nx != st) cnt <= '0;
      else if (cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
      if (st == S_FS_IDLE && se0_now) begin
        if (se0_cnt != SW'(SE0_CYCLES)) se0_cnt <= se0_cnt + 1'b1;
      end else begin
        se0_cnt <= '0;
      end
    end
  end

  assign phy_rst    = (st == S_RESET);
  assign req_valid  = (st inside {S_OTG_OFF, S_FS_SEL, S_HS_SEL, S_CHIRP});
  assign state      = st;
  assign line_state = ls_q;
  assign err        = (st == S_ERR);
endmodule

// File: rtl/usb_attach_seq_chk.sv
module usb_attach_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phy_rst,
  input logic       req_valid,
  input logic       req_ack,
  input logic [7:0] req_cmd,
  input logic [7:0] req_data,
  input logic [3:0] state,
  input logic [1:0] line_state,
  input logic       done,
  input logic       err
);
  a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rst |-> !req_valid);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ack) |=> (err || (req_valid && $stable(req_cmd) && $stable(req_data))));

  a_r3_otg_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd4 && $past(state) != 4'd4) |-> $past(state) == 4'd3);

  a_r7_hs_after_se0: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd8 && $past(state) == 4'd7) |-> $past(line_state) == 2'b00);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> state == 4'd10);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && state == 4'd15));
endmodule

bind usb_attach_seq usb_attach_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .phy_rst(phy_rst), .req_valid(req_valid),
  .req_ack(req_ack), .req_cmd(req_cmd), .req_data(req_data), .state(state),
  .line_state(line_state), .done(done), .err(err)
);

// File: tb/usb_attach_seq_test.sv
module usb_attach_seq_test;
  localparam int RSTN = 16;
  localparam int SE0N = 20;
  localparam int TMO  = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0, dir = 1'b0, nxt = 1'b0, ack = 1'b0;
  logic [7:0] data = 8'h00;
  logic       phy_rst, req_valid, done, err;
  logic [7:0] req_cmd, req_data;
  logic [3:0] state;
  logic [1:0] line_state;
  int tests = 0, fails = 0;

  usb_attach_seq #(.RST_CYCLES(RSTN), .SE0_CYCLES(SE0N), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .phy_dir(dir), .phy_nxt(nxt), .phy_data(data),
    .req_ack(ack), .phy_rst(phy_rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_data(req_data), .state(state), .line_state(line_state), .done(done), .err(err));

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dir = 1'b0; nxt = 1'b0; ack = 1'b0; data = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 phy_rst in reset", phy_rst, 1);
    check("R1 state in reset", state, 0);
    check("R1 no request in reset", req_valid, 0);
    rst_n = 1'b1;
    #0;
    begin
      int n = 0;
      while (phy_rst && n < 1000) begin n++; @(negedge clk); end
      check("R1 reset pulse length", n, RSTN);
    end
    check("R2 waiting for dir high", state, 1);
  endtask

  task automatic rxcmd(input logic [1:0] ls);
    @(negedge clk); dir = 1'b1; nxt = 1'b0; data = 8'h00;
    @(negedge clk); data = {6'b0, ls};
    @(negedge clk); dir = 1'b0; data = 8'h00;
  endtask

  task automatic serve(input logic [7:0] c, input logic [7:0] d, input int dly, input string req);
    int n = 0;
    while (!req_valid && n < 200) begin @(negedge clk); n++; end
    check({req, " request raised"}, req_valid, 1);
    check({req, " cmd"}, req_cmd, c);
    check({req, " data"}, req_data, d);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check({req, " held cmd"}, req_cmd, c);
      check({req, " held valid"}, req_valid, 1);
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic to_first_rx();
    do_reset();
    @(negedge clk); dir = 1'b1;
    @(negedge clk);
    check("R2 saw dir high", state, 2);
    dir = 1'b0;
    @(negedge clk);
    check("R2 saw dir low", state, 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // Full bring-up
    do_reset();
    repeat (5) @(negedge clk);
    check("R2 still waiting", state, 1);
    check("R2 no request early", req_valid, 0);
    @(negedge clk); dir = 1'b1;
    @(negedge clk);
    check("R2 saw dir high", state, 2);
    repeat (3) @(negedge clk);
    check("R2 held while dir high", state, 2);
    dir = 1'b0;
    @(negedge clk);
    check("R2 saw dir low", state, 3);
    check("R2 no request before rxcmd", req_valid, 0);

    // R3: dir high with nxt high is not a receive command
    dir = 1'b1; nxt = 1'b1; data = 8'h01;
    repeat (2) @(negedge clk);
    dir = 1'b0; nxt = 1'b0; data = 8'h00;
    @(negedge clk);
    check("R3 nxt high ignored", state, 3);
    rxcmd(2'b10);
    check("R3 line state captured", line_state, 2);
    check("R3 first rxcmd advances", state, 4);

    serve(8'h8A, 8'h00, 3, "R4");
    check("R4 ack advances", state, 5);
    serve(8'h84, 8'h45, 0, "R5");
    check("R5 ack advances", state, 6);
    check("R5 request dropped", req_valid, 0);

    rxcmd(2'b10);
    check("R6 K keeps waiting", state, 6);
    rxcmd(2'b00);
    check("R6 SE0 keeps waiting", state, 6);
    rxcmd(2'b01);
    check("R6 J reaches idle", state, 7);
    check("R6 line state J", line_state, 1);

    // R7 sweep: SE0 runs of w+3 cycles broken by J
    for (int w = 0; w <= SE0N - 4; w++) begin
      rxcmd(2'b00);
      repeat (w) @(negedge clk);
      rxcmd(2'b01);
      check("R7 short SE0 ignored", state, 7);
    end
    check("R7 line state back to J", line_state, 1);
    rxcmd(2'b00);
    repeat (SE0N - 2) @(negedge clk);
    check("R7 one cycle short", state, 7);
    @(negedge clk);
    check("R7 qualified SE0", state, 8);

    serve(8'h84, 8'h54, 2, "R8");
    check("R8 ack advances", state, 9);
    serve(8'h40, 8'h00, 1, "R9");
    check("R9 done pulse", done, 1);
    check("R9 done state", state, 10);
    @(negedge clk);
    check("R9 done cleared", done, 0);
    check("R9 stays done", state, 10);
    check("R9 no further request", req_valid, 0);

    // R10: timeout waiting for dir high
    do_reset();
    begin
      int n = 0;
      while (state == 4'd1 && n < 1000) begin n++; @(negedge clk); end
      check("R10 dir-high timeout length", n, TMO);
    end
    check("R10 error state", state, 15);
    check("R10 err flag", err, 1);
    dir = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 error sticky", state, 15);

    // R10: timeout waiting for the engine
    to_first_rx();
    rxcmd(2'b01);
    begin
      int n = 0;
      while (state == 4'd4 && n < 1000) begin n++; @(negedge clk); end
      check("R10 ack timeout length", n, TMO);
    end
    check("R10 err after ack timeout", err, 1);
    check("R10 request withdrawn", req_valid, 0);

    // R10: timeout waiting for J
    to_first_rx();
    rxcmd(2'b01);
    serve(8'h8A, 8'h00, 0, "R4");
    serve(8'h84, 8'h45, 0, "R5");
    begin
      int n = 0;
      while (state == 4'd6 && n < 1000) begin n++; @(negedge clk); end
      check("R10 J timeout length", n, TMO);
    end
    check("R10 err after J timeout", err, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule